// File: doc/BRIEF.md
# Address-Filtering Serial Receiver for Shared Multi-Node Lines

This block is an asynchronous serial receiver for a bus where one talker addresses many listeners over a single line. Every character carries a type tag that marks it as an address or as payload. While the node's filter is switched on, the receiver drops payload characters silently and passes only address characters. When an accepted address equals the node's own address, the block switches its filter off by itself. From then on, payload characters reach the host until the host switches the filter back on.

The line is oversampled sixteen times per bit from a plain clock divider. The character length can be set from five to nine bits. With five to eight bits, the tag sits in the first stop position, so the talker must send two stop bits. With nine bits, the ninth bit is the tag. The host sees one holding register with the data byte, the tag bit, a framing-error bit and an available flag. It empties the register by pulsing an acknowledge input. An overrun flag marks a character that was lost because the register was still full.

Top module: `mpurx_top`

## Requirements
- R1: The line is sampled once per 16 oversample ticks, one tick every CLK_DIV clocks, near the middle of each bit. A falling edge starts a character only if the line is still low at the middle of the start bit. A shorter low pulse is ignored.
- R2: `cfg_bits` sets the number of data bits, 5 to 9. Values below 5 act as 5 and values above 9 act as 9. Data arrives LSB first, and the unused upper bits of `rd_data` read 0.
- R3: The type tag is the first stop bit for 5 to 8 data bits and the ninth data bit for 9 data bits. It is shown on `rd_tag`. A tag of 1 means address and 0 means payload.
- R4: While `filt_en` is 0, every completed character is loaded and raises `rd_avail`.
- R5: While `filt_en` is 1, a payload character changes neither `rd_avail`, `rd_data` nor `rd_ovr`. An address character is loaded as in R4.
- R6: Suppose an address character is loaded while `filt_en` is 1 and its low eight data bits equal `node_addr`. Then `filt_en` reads 0 from the next cycle. A non-matching address leaves `filt_en` at 1.
- R7: A `filt_set` pulse makes `filt_en` 1 and a `filt_clr` pulse makes it 0. When both are high in the same cycle, set wins.
- R8: The stop bit that is not the tag is checked: the second stop bit for 5 to 8 data bits, the only stop bit for 9 data bits. If it is sampled low, `rd_ferr` is stored as 1 with the character.
- R9: If a character that would be loaded completes while `rd_avail` is 1 and `rd_ack` is low, `rd_ovr` becomes 1 and the character is dropped, so `rd_data` keeps the older byte. A pulse on `rd_ack` clears both `rd_avail` and `rd_ovr`.
- R10: If `rd_ack` is high in the cycle a character completes, the new character is loaded, `rd_avail` stays 1 and no overrun is flagged.
- R11: After reset, `rd_avail`, `rd_ovr` and `filt_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| cfg_bits | input | 4 | Data bits per character (5 to 9) |
| node_addr | input | 8 | This node's address |
| filt_set | input | 1 | Switch the filter on |
| filt_clr | input | 1 | Switch the filter off |
| filt_en | output | 1 | Filter state |
| rd_ack | input | 1 | Host has taken the holding register |
| rd_data | output | 8 | Received data bits |
| rd_tag | output | 1 | Type tag / ninth bit of the held character |
| rd_ferr | output | 1 | Framing error of the held character |
| rd_avail | output | 1 | Holding register full |
| rd_ovr | output | 1 | A character was lost to a full register |

## Verification
A character can complete in the same cycle as the host acknowledges the previous one. In that cycle the load and the release of the holding register have to merge without raising an overrun. The bench provokes this by sweeping a one-cycle acknowledge across every clock around the end of a second character, with the first character still unread. Each outcome must be either the new byte held with no overrun, or the old byte released with no overrun. Across the sweep the outcome must switch from new to old exactly once.

// File: rtl/mpurx_pkg.sv
package mpurx_pkg;

    localparam int DATA_W = 8;
    localparam int SHR_W  = DATA_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic              avail;
        logic              ovr;
        logic              filt;
        logic              tag;
        logic              ferr;
        logic [DATA_W-1:0] data;
    } hold_s;

endpackage

// File: rtl/mpurx_tick.sv
module mpurx_tick #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          tick_d, tick_q;

    always_comb begin
        tick_d = 1'b0;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == LAST) begin
            cnt_d  = '0;
            tick_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            tick_q <= tick_d;
        end
    end

    assign tick = tick_q;

endmodule

// File: rtl/mpurx_frame.sv
module mpurx_frame
    import mpurx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rxd,
    input  logic [3:0]       nbits,
    output logic             f_done,
    output logic [SHR_W-1:0] f_data,
    output logic             f_tag,
    output logic             f_ferr
);
    localparam int OW = $clog2(OVS);
    localparam logic [OW-1:0] MID  = OW'(OVS / 2 - 1);
    localparam logic [OW-1:0] LAST = OW'(OVS - 1);

    typedef struct packed {
        rx_state_e        st;
        logic [OW-1:0]    ovs;
        logic [3:0]       idx;
        logic [SHR_W-1:0] sh;
        logic             tag;
        logic             ferr;
        logic             done;
    } frm_s;

    frm_s d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (tick && !rxd) begin
                    d.st  = ST_START;
                    d.ovs = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (q.ovs == MID) begin
                        if (!rxd) begin
                            d.st  = ST_DATA;
                            d.ovs = '0;
                            d.idx = '0;
                            d.sh  = '0;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end else begin
                        d.ovs = q.ovs + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (q.ovs == LAST) begin
                        d.ovs        = '0;
                        d.sh[q.idx]  = rxd;
                        if (q.idx == nbits - 4'd1) begin
                            d.st  = ST_STOP;
                            d.idx = '0;
                        end else begin
                            d.idx = q.idx + 4'd1;
                        end
                    end else begin
                        d.ovs = q.ovs + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (q.ovs == LAST) begin
                        d.ovs = '0;
                        if (nbits == 4'd9) begin
                            d.tag  = q.sh[SHR_W-1];
                            d.ferr = !rxd;
                            d.done = 1'b1;
                            d.st   = ST_IDLE;
                        end else if (q.idx == 4'd0) begin
                            d.tag = rxd;
                            d.idx = 4'd1;
                        end else begin
                            d.ferr = !rxd;
                            d.done = 1'b1;
                            d.st   = ST_IDLE;
                        end
                    end else begin
                        d.ovs = q.ovs + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ovs: '0, idx: '0, sh: '0, tag: 1'b0, ferr: 1'b0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign f_done = q.done;
    assign f_data = q.sh;
    assign f_tag  = q.tag;
    assign f_ferr = q.ferr;

    // R2: bit index never runs past the widest character
    a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DATA) |-> (q.idx <= 4'd8));

    // R1: a start bit that is high again at its middle is abandoned
    a_r1_start_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_START && tick && q.ovs == MID && rxd) |=> (q.st == ST_IDLE));

    // R3: a character completes only out of the stop phase
    a_r3_done_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> ($past(q.st) == ST_STOP));

endmodule

// File: rtl/mpurx_hold.sv
module mpurx_hold
    import mpurx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              f_done,
    input  logic [SHR_W-1:0]  f_data,
    input  logic              f_tag,
    input  logic              f_ferr,
    input  logic [DATA_W-1:0] node_addr,
    input  logic              filt_set,
    input  logic              filt_clr,
    input  logic              rd_ack,
    output hold_s             hold
);
    hold_s d, q;
    logic  free, accept, hit;

    always_comb begin
        d      = q;
        free   = !q.avail || rd_ack;
        accept = f_done && (!q.filt || f_tag);
        hit    = accept && free && f_tag && q.filt && (f_data[DATA_W-1:0] == node_addr);
        if (rd_ack) begin
            d.avail = 1'b0;
            d.ovr   = 1'b0;
        end
        if (accept) begin
            if (free) begin
                d.avail = 1'b1;
                d.data  = f_data[DATA_W-1:0];
                d.tag   = f_tag;
                d.ferr  = f_ferr;
            end else begin
                d.ovr = 1'b1;
            end
        end
        if (filt_clr || hit) d.filt = 1'b0;
        if (filt_set)        d.filt = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign hold = q;

    // R5: payload under an active filter leaves the holding register untouched
    a_r5_payload_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (f_done && q.filt && !f_tag && !rd_ack) |=> ($stable(q.avail) && $stable(q.data) && $stable(q.ovr)));

    // R9: full register and no acknowledge drops the new character
    a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (f_done && (!q.filt || f_tag) && q.avail && !rd_ack) |=> (q.ovr && $stable(q.data)));

    // R10: acknowledge in the completion cycle loads without overrun
    a_r10_ack_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (f_done && (!q.filt || f_tag) && rd_ack) |=> (q.avail && !q.ovr));

    // R7: set has priority
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        filt_set |=> q.filt);

    // R6: own address turns the filter off
    a_r6_match_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (f_done && f_tag && q.filt && !q.avail && f_data[DATA_W-1:0] == node_addr && !filt_set)
        |=> !q.filt);

endmodule

// File: rtl/mpurx_top.sv
module mpurx_top
    import mpurx_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int OVS     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic [3:0]        cfg_bits,
    input  logic [DATA_W-1:0] node_addr,
    input  logic              filt_set,
    input  logic              filt_clr,
    output logic              filt_en,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_tag,
    output logic              rd_ferr,
    output logic              rd_avail,
    output logic              rd_ovr
);
    localparam int SYNC_N = 2;

    logic [SYNC_N-1:0] sync_d, sync_q;
    logic              tick;
    logic [3:0]        nbits;
    logic              f_done, f_tag, f_ferr;
    logic [SHR_W-1:0]  f_data;
    hold_s             hold;

    always_comb begin
        sync_d = {sync_q[SYNC_N-2:0], rxd};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    always_comb begin
        if (cfg_bits < 4'd5)      nbits = 4'd5;
        else if (cfg_bits > 4'd9) nbits = 4'd9;
        else                      nbits = cfg_bits;
    end

    mpurx_tick #(.CLK_DIV(CLK_DIV)) i_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    mpurx_frame #(.OVS(OVS)) i_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .rxd   (sync_q[SYNC_N-1]),
        .nbits (nbits),
        .f_done(f_done),
        .f_data(f_data),
        .f_tag (f_tag),
        .f_ferr(f_ferr)
    );

    mpurx_hold i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .f_done   (f_done),
        .f_data   (f_data),
        .f_tag    (f_tag),
        .f_ferr   (f_ferr),
        .node_addr(node_addr),
        .filt_set (filt_set),
        .filt_clr (filt_clr),
        .rd_ack   (rd_ack),
        .hold     (hold)
    );

    assign filt_en  = hold.filt;
    assign rd_data  = hold.data;
    assign rd_tag   = hold.tag;
    assign rd_ferr  = hold.ferr;
    assign rd_avail = hold.avail;
    assign rd_ovr   = hold.ovr;

    // R11: flags clear right after reset release
    a_r11_reset_flags: assert property (@(posedge clk)
        $rose(rst_n) |-> (!rd_avail && !rd_ovr && !filt_en));

endmodule

// File: tb/test_mpurx_top.sv
module test_mpurx_top;
    localparam int DIV = 2;
    localparam int BITCLK = 16 * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic [3:0] cfg_bits = 4'd8;
    logic [7:0] node_addr = 8'h5A;
    logic       filt_set = 1'b0, filt_clr = 1'b0, rd_ack = 1'b0;
    logic       filt_en, rd_tag, rd_ferr, rd_avail, rd_ovr;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    mpurx_top #(.CLK_DIV(DIV)) i_mpurx_top (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .cfg_bits(cfg_bits),
        .node_addr(node_addr), .filt_set(filt_set), .filt_clr(filt_clr),
        .filt_en(filt_en), .rd_ack(rd_ack), .rd_data(rd_data), .rd_tag(rd_tag),
        .rd_ferr(rd_ferr), .rd_avail(rd_avail), .rd_ovr(rd_ovr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic line_bit(input logic v);
        rxd = v;
        clks(BITCLK);
    endtask

    function automatic int eff_bits(input int nb);
        return nb < 5 ? 5 : (nb > 9 ? 9 : nb);
    endfunction

    function automatic logic [7:0] mask_data(input int nb, input logic [7:0] d);
        int n = eff_bits(nb);
        return (n >= 8) ? d : (d & 8'((1 << n) - 1));
    endfunction

    // start, data LSB first, tag (first stop or ninth bit), checked stop
    task automatic send(input int nb, input logic [7:0] d, input logic tag, input logic badstop);
        int n = eff_bits(nb);
        cfg_bits = 4'(nb);
        line_bit(1'b0);
        for (int i = 0; i < (n > 8 ? 8 : n); i++) line_bit(d[i]);
        line_bit(tag);
        if (badstop) begin
            rxd = 1'b0; clks(22);
            rxd = 1'b1; clks(BITCLK - 22);
        end else begin
            line_bit(1'b1);
        end
        clks(2 * BITCLK);
    endtask

    task automatic ack;
        rd_ack = 1'b1; clks(1); rd_ack = 1'b0; clks(1);
    endtask

    task automatic pulse_set;
        filt_set = 1'b1; clks(1); filt_set = 1'b0; clks(1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int outcome, prev, switches, first, last;
        logic exp_filt;
        clks(5);
        rst_n = 1'b1;
        clks(2);
        // R11 reset state
        check("R11 avail", rd_avail, 0);
        check("R11 ovr", rd_ovr, 0);
        check("R11 filt", filt_en, 0);

        // R4: filter off, payload delivered
        send(8, 8'hC3, 1'b0, 1'b0);
        check("R4 avail", rd_avail, 1);
        check("R4 data", rd_data, 8'hC3);
        check("R3 tag payload", rd_tag, 0);
        check("R8 ferr clean", rd_ferr, 0);
        ack();
        check("R9 ack clears", rd_avail, 0);

        // R1: short low glitch is not a start
        rxd = 1'b0; clks(6); rxd = 1'b1; clks(3 * BITCLK);
        check("R1 glitch ignored", rd_avail, 0);

        // R7 set wins over clear
        filt_set = 1'b1; filt_clr = 1'b1; clks(1);
        filt_set = 1'b0; filt_clr = 1'b0; clks(1);
        check("R7 set wins", filt_en, 1);

        // R5 payload dropped with filter on
        send(8, 8'h11, 1'b0, 1'b0);
        check("R5 payload dropped", rd_avail, 0);
        // R6 foreign address kept filter on
        send(8, 8'h33, 1'b1, 1'b0);
        check("R5 address passes", rd_avail, 1);
        check("R3 tag address", rd_tag, 1);
        check("R6 foreign keeps filter", filt_en, 1);
        ack();
        send(8, 8'h44, 1'b0, 1'b0);
        check("R5 still dropping", rd_avail, 0);
        // R6 own address opens the filter
        send(8, 8'h5A, 1'b1, 1'b0);
        check("R6 own address held", rd_data, 8'h5A);
        check("R6 filter opened", filt_en, 0);
        ack();
        send(8, 8'h77, 1'b0, 1'b0);
        check("R4 payload after open", rd_data, 8'h77);
        check("R4 payload avail", rd_avail, 1);
        ack();
        pulse_set();
        send(8, 8'h78, 1'b0, 1'b0);
        check("R5 payload stops after set", rd_avail, 0);
        filt_clr = 1'b1; clks(1); filt_clr = 1'b0; clks(1);
        check("R7 clear", filt_en, 0);

        // R2/R3 nine-bit characters, R8 on the only stop bit
        send(9, 8'hA5, 1'b1, 1'b0);
        check("R2 nine data", rd_data, 8'hA5);
        check("R3 ninth bit", rd_tag, 1);
        ack();
        send(9, 8'h0F, 1'b0, 1'b1);
        check("R8 nine ferr", rd_ferr, 1);
        check("R3 ninth bit zero", rd_tag, 0);
        ack();
        // R2 five bits, upper zero; R8 second stop low
        send(5, 8'hFF, 1'b0, 1'b1);
        check("R2 five bits", rd_data, 8'h1F);
        check("R8 five ferr", rd_ferr, 1);
        ack();
        // R2 clamp of out-of-range setting
        send(3, 8'hFF, 1'b0, 1'b0);
        check("R2 clamp low", rd_data, 8'h1F);
        ack();

        // R9 overrun keeps old byte
        send(8, 8'h21, 1'b0, 1'b0);
        send(8, 8'h22, 1'b0, 1'b0);
        check("R9 ovr set", rd_ovr, 1);
        check("R9 old byte kept", rd_data, 8'h21);
        ack();
        check("R9 ack clears ovr", rd_ovr, 0);

        // R10 acknowledge swept across completion of a second character
        prev = -1; switches = 0; first = -1; last = -1;
        for (int off = 290; off < 370; off++) begin
            send(8, 8'hA1, 1'b0, 1'b0);
            fork
                send(8, 8'hB2, 1'b0, 1'b0);
                begin clks(off); rd_ack = 1'b1; clks(1); rd_ack = 1'b0; end
            join
            if (rd_ovr !== 1'b0) check("R10 no overrun", rd_ovr, 0);
            if (rd_avail && rd_data == 8'hB2) outcome = 1;
            else if (!rd_avail && rd_data == 8'hA1) outcome = 0;
            else begin
                outcome = 2;
                check("R10 legal outcome", {rd_avail, rd_data}, 9'h1B2);
            end
            if (first < 0) first = outcome;
            if (prev >= 0 && outcome != prev) switches++;
            prev = outcome; last = outcome;
            ack();
        end
        check("R10 early ack keeps new", first, 1);
        check("R10 late ack keeps old", last, 0);
        check("R10 single switch", switches, 1);

        // random mix against a bench model (R3 R4 R5 R6)
        void'($urandom(32'd1234));
        exp_filt = filt_en;
        for (int k = 0; k < 24; k++) begin
            int nb;
            logic tag;
            logic [7:0] dat;
            nb  = 5 + int'($urandom % 5);
            tag = 1'($urandom % 2);
            dat = 8'($urandom);
            if (($urandom % 3) == 0) dat = node_addr;
            if (($urandom % 4) == 0) begin pulse_set(); exp_filt = 1'b1; end
            send(nb, dat, tag, 1'b0);
            if (exp_filt && !tag) begin
                check("R5 random drop", rd_avail, 0);
            end else begin
                check("R4 random avail", rd_avail, 1);
                check("R2 random data", rd_data, mask_data(nb, dat));
                check("R3 random tag", rd_tag, tag);
                if (exp_filt && tag && mask_data(nb, dat) == node_addr) exp_filt = 1'b0;
            end
            check("R6 random filter", filt_en, exp_filt);
            if (rd_avail) ack();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule